// File: doc/BRIEF.md
# Serial Programming Register Router

This block receives configuration words over a three-wire serial write bus made of a serial clock, a data line and a load strobe. Each word is 24 bits long and is shifted in most significant bit first. When the load strobe rises, the word is copied into one of four holding registers. The two lowest bits of the word pick the destination register. The other 22 bits are the payload.

The held outputs are:
- a 22-bit control register;
- a 14-bit reference divider value;
- an 18-bit feedback divider value, split into a 5-bit A field and a 13-bit B field;
- a 22-bit test register, which normal configuration leaves unwritten.

A one-cycle pulse marks each load of the feedback register. Downstream logic can use it to start work that must follow a divider change.

The three serial lines may be asynchronous to the system clock. Each line is synchronised into the system clock domain and its edges are detected there. The bus has no back-pressure. The writer paces itself by holding each level for at least three system clock cycles.

Top module: `ser_prog_router`

## Requirements
- R1: After reset, every held output and the update pulse are zero.
- R2: Each rising serial clock edge shifts one data bit into a 24-bit register. The first bit sent ends up as word bit 23 (MSB first).
- R3: A load with word bits [1:0] = 00 sets the control output to word bits [23:2].
- R4: A load with bits [1:0] = 01 sets the reference divider output to word bits [15:2].
- R5: A load with bits [1:0] = 10 sets the A output to word bits [6:2] and the B output to word bits [19:7].
- R6: A load with bits [1:0] = 11 sets the test output to word bits [23:2].
- R7: A load changes only the register its address selects. The other three registers hold their values.
- R8: The update pulse is high for exactly one system clock cycle for each feedback register load, and never for a load to any other register.
- R9: When more than 24 bits are shifted before a load, only the last 24 bits are used.
- R10: A transfer happens only on a rising edge of the load strobe. Shifting bits, or holding the strobe high, changes no output. A later new rising edge transfers the word then held in the shift register.
- R11: The serial lines are synchronised, so the outputs react only after a fixed delay of a few system clock cycles. The writer must hold each level for at least three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| sclk_i | input | 1 | Serial clock; data is captured on its rising edge |
| sdat_i | input | 1 | Serial data, MSB first |
| ld_i | input | 1 | Load strobe; its rising edge transfers the word |
| ctrl_o | output | 22 | Held control register |
| ref_div_o | output | 14 | Held reference divider value |
| fb_a_o | output | 5 | Held feedback divider A field |
| fb_b_o | output | 13 | Held feedback divider B field |
| test_o | output | 22 | Held test register |
| fb_upd_o | output | 1 | One-cycle pulse on each feedback register load |

## Verification
One word is sent to each of the four addresses. Each payload has a distinct bit pattern, so a swapped field, a shifted slice or a reversed bit order gives a visibly wrong value. All four outputs are checked after every load, which separates a misdecoded address from a write that also reaches another register.

A 32-bit burst checks that the oldest bits are pushed out. A word shifted while the strobe stays high checks that only a strobe edge transfers data. Counting update pulses across all writes checks that only feedback loads produce one, and exactly one each.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Destination codes carried in the two low bits of each word
  typedef enum logic [1:0] {
    DST_CTRL = 2'b00,
    DST_REF  = 2'b01,
    DST_FB   = 2'b10,
    DST_TEST = 2'b11
  } dst_e;

  localparam int WORD_W = 24;
  localparam int ADDR_W = 2;
  localparam int REF_W  = 14;
  localparam int A_W    = 5;
  localparam int B_W    = 13;
endpackage

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;

    // R11
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic         bit_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh_q <= '0;
    else if (step_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign word_o = sh_q;

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (word_o[0] == $past(bit_i)) && (word_o[W-1:1] == $past(word_o[W-2:0])));
  // R10
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(word_o));
endmodule

// File: rtl/ser_route.sv
module ser_route
  import ser_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int AW   = ADDR_W,
  parameter int RW   = REF_W,
  parameter int AFW  = A_W,
  parameter int BFW  = B_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [W-1:0]      word_i,
  output logic [W-AW-1:0]   ctrl_o,
  output logic [RW-1:0]     ref_o,
  output logic [AFW+BFW-1:0] fb_o,
  output logic [W-AW-1:0]   test_o,
  output logic              fb_upd_o
);
  localparam int PAY_W = W - AW;
  localparam int FB_W  = AFW + BFW;

  dst_e             dst;
  logic [PAY_W-1:0] pay;
  logic [PAY_W-1:0] ctrl_q, test_q;
  logic [RW-1:0]    ref_q;
  logic [FB_W-1:0]  fb_q;
  logic             upd_q;

  assign dst = dst_e'(word_i[AW-1:0]);
  assign pay = word_i[W-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      ref_q  <= '0;
      fb_q   <= '0;
      test_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (load_i) begin
        unique case (dst)
          DST_CTRL: ctrl_q <= pay;
          DST_REF:  ref_q  <= pay[RW-1:0];
          DST_FB: begin
            fb_q  <= pay[FB_W-1:0];
            upd_q <= 1'b1;
          end
          DST_TEST: test_q <= pay;
        endcase
      end
    end
  end

  assign ctrl_o   = ctrl_q;
  assign ref_o    = ref_q;
  assign fb_o     = fb_q;
  assign test_o   = test_q;
  assign fb_upd_o = upd_q;

  // R3
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[AW-1:0] == 2'b00) |=> ctrl_o == $past(word_i[W-1:AW]));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(ctrl_o) && $stable(ref_o) && $stable(fb_o) && $stable(test_o));
  // R8
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_upd_o |=> !fb_upd_o);
  // R8
  upd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_upd_o |-> $past(load_i) && fb_o == $past(word_i[AW+FB_W-1:AW]));
endmodule

// File: rtl/ser_prog_router.sv
module ser_prog_router
  import ser_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              ld_i,
  output logic [WORD_W-ADDR_W-1:0] ctrl_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic [A_W-1:0]    fb_a_o,
  output logic [B_W-1:0]    fb_b_o,
  output logic [WORD_W-ADDR_W-1:0] test_o,
  output logic              fb_upd_o
);
  localparam int NCH = 3;

  logic [NCH-1:0]    lvl, rise;
  logic [WORD_W-1:0] word;
  logic [A_W+B_W-1:0] fb;

  ser_sync #(.N(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ld_i, sdat_i, sclk_i}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  ser_shift #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .step_i(rise[0]),
    .bit_i (lvl[1]),
    .word_o(word)
  );

  ser_route u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (rise[2]),
    .word_i  (word),
    .ctrl_o  (ctrl_o),
    .ref_o   (ref_div_o),
    .fb_o    (fb),
    .test_o  (test_o),
    .fb_upd_o(fb_upd_o)
  );

  assign fb_a_o = fb[A_W-1:0];
  assign fb_b_o = fb[A_W+B_W-1:A_W];

  // R10
  no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise[2] |=> !fb_upd_o);
endmodule

// File: tb/test_ser_prog_router.sv
module test_ser_prog_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, ld = 1'b0;
  logic [21:0] ctrl, test;
  logic [13:0] refd;
  logic [4:0]  fa;
  logic [12:0] fbb;
  logic        upd;
  int checks = 0, fails = 0, pulses = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  ser_prog_router i_ser_prog_router (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .ld_i(ld),
    .ctrl_o(ctrl), .ref_div_o(refd), .fb_a_o(fa), .fb_b_o(fbb),
    .test_o(test), .fb_upd_o(upd)
  );

  always @(posedge clk) if (upd) pulses++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = bits[i];
      wait_cyc(4);
      sclk = 1'b1;
      wait_cyc(4);
      sclk = 1'b0;
    end
    wait_cyc(4);
  endtask

  task automatic load();
    ld = 1'b1;
    wait_cyc(4);
    ld = 1'b0;
    wait_cyc(4);
  endtask

  task automatic expect_all(string req, logic [21:0] c, logic [13:0] r,
                            logic [4:0] a, logic [12:0] b, logic [21:0] t);
    chk({req, " ctrl"}, 32'(ctrl), 32'(c));
    chk({req, " ref"},  32'(refd), 32'(r));
    chk({req, " A"},    32'(fa),   32'(a));
    chk({req, " B"},    32'(fbb),  32'(b));
    chk({req, " test"}, 32'(test), 32'(t));
  endtask

  task automatic t_reset();
    expect_all("R1", '0, '0, '0, '0, '0);
    chk("R1 pulse", 32'(upd), 0);
  endtask

  task automatic t_ctrl();
    send_bits({40'h0, 22'h2A5C3F, 2'b00}, 24);
    chk("R10 shift only", 32'(ctrl), 0);
    load();
    expect_all("R3/R7", 22'h2A5C3F, '0, '0, '0, '0);
  endtask

  task automatic t_ref();
    send_bits({40'h0, 8'hA5, 14'h2D6B, 2'b01}, 24);
    load();
    expect_all("R4/R7", 22'h2A5C3F, 14'h2D6B, '0, '0, '0);
    chk("R8 no pulse on ref", 32'(pulses), 0);
  endtask

  task automatic t_fb();
    send_bits({40'h0, 4'h9, 13'h1ABC, 5'h13, 2'b10}, 24);
    load();
    expect_all("R5/R7", 22'h2A5C3F, 14'h2D6B, 5'h13, 13'h1ABC, '0);
    chk("R8 one pulse", 32'(pulses), 1);
  endtask

  task automatic t_test();
    send_bits({40'h0, 22'h155AA1, 2'b11}, 24);
    load();
    expect_all("R6/R7", 22'h2A5C3F, 14'h2D6B, 5'h13, 13'h1ABC, 22'h155AA1);
    chk("R8 no pulse on test", 32'(pulses), 1);
  endtask

  task automatic t_overlong();
    send_bits({32'h0, 8'hFF, 8'h00, 14'h0123, 2'b01}, 32);
    load();
    chk("R9 last 24 bits", 32'(refd), 32'h0123);
    chk("R9 ctrl kept", 32'(ctrl), 32'h2A5C3F);
  endtask

  task automatic t_level();
    ld = 1'b1;
    wait_cyc(4);
    send_bits({40'h0, 22'h03C3C3, 2'b00}, 24);
    chk("R10 held strobe", 32'(ctrl), 32'h2A5C3F);
    ld = 1'b0;
    wait_cyc(4);
    chk("R10 falling edge", 32'(ctrl), 32'h2A5C3F);
    load();
    chk("R10 new edge", 32'(ctrl), 32'h03C3C3);
    chk("R8 count final", 32'(pulses), 1);
  endtask

  task automatic t_fb_again();
    send_bits({40'h0, 4'h0, 13'h0001, 5'h1F, 2'b10}, 24);
    load();
    chk("R5 A second", 32'(fa), 32'h1F);
    chk("R5 B second", 32'(fbb), 32'h0001);
    chk("R8 second pulse", 32'(pulses), 2);
  endtask

  initial begin
    wait_cyc(5);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_ctrl();
    t_ref();
    t_fb();
    t_test();
    t_overlong();
    t_level();
    t_fb_again();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule